// File: doc/BRIEF.md
# Log-Domain Linear-Kernel Support Vector Classifier

This block decides which of two classes a test vector belongs to, using a trained two-class support vector machine with a linear kernel. Every number it handles is a logarithmic-format word. A product is formed by adding two base-2 logarithms and combining the two sign bits. A sum is formed by a log-domain add/subtract step. That step corrects the larger operand's logarithm by a small amount taken from the difference between the two logarithms.

Software loads the trained model into internal registers through a single write port. The model is the support-vector attribute values, one signed weight per support vector (the training multiplier already multiplied by the class label) and a bias. The test attributes go in through the same port. A start pulse makes the block step one attribute per clock through every support vector. For each support vector it builds the dot product with the test vector, scales it by that vector's weight and adds it to a running total that begins at the bias. When the walk ends it reports only the sign of the total, together with a one-cycle done pulse. Attribute values are expected to be already scaled and centred on zero. Conversion into the log domain happens outside the block.

Top module: `lns_svm_classifier`

## Requirements
- R1: A data word is 12 bits. Bit 11 set marks an exact zero, whatever the other bits hold. Bit 10 is the sign (1 = negative). Bits 9:0 hold the two's-complement base-2 logarithm of the magnitude, with 4 fraction bits.
- R2: A write takes place at a rising clock edge when `ld_en` is high and the block is idle. `ld_sel` picks the target: 0 writes test attribute `ld_att`; 1 writes attribute `ld_att` of support vector `ld_sv`; 2 writes the weight of support vector `ld_sv`; 3 writes the bias.
- R3: At the end of a run, `cls_pos` is 1 when the bias plus the sum over support vectors of weight times dot product is positive, and 0 when that total is negative.
- R4: A product has a logarithm equal to the sum of the operand logarithms and a sign equal to the XOR of the operand signs. If either operand is an exact zero, the product is an exact zero.
- R5: Adding two values of the same sign keeps that sign and never shrinks the magnitude. Adding two values of equal magnitude and opposite sign gives an exact zero. Adding an exact zero returns the other operand unchanged.
- R6: A final total that is an exact zero is reported as `cls_pos` = 1.
- R7: `done` is high for exactly one cycle. It rises at the NSV·(NATT+1)-th rising edge after the edge that accepts `start`. `cls_pos` changes only together with `done` and holds its value between runs.
- R8: A `start` that arrives while a run is in progress has no effect. The run keeps its timing and produces exactly one `done`.
- R9: Writes presented while a run is in progress are discarded. The run in progress and later runs see the stored values unchanged.
- R10: A `start` presented in the cycle in which `done` is high begins a new run at once.
- R11: Synchronous active-high reset clears `done` and `cls_pos` to 0 and sets every stored word to an exact zero.
- R12: A logarithm that exceeds the 10-bit range saturates to the largest (or smallest) representable value. It does not wrap around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write strobe for the model and test registers |
| ld_sel | input | 2 | Write target select (R2) |
| ld_sv | input | max(1,clog2(NSV)) | Support-vector index for a write |
| ld_att | input | max(1,clog2(NATT)) | Attribute index for a write |
| ld_word | input | 12 | Logarithmic data word to write (R1) |
| start | input | 1 | Begin classifying the stored test vector |
| done | output | 1 | One-cycle pulse when `cls_pos` is fresh |
| cls_pos | output | 1 | 1 = positive class, 0 = negative class |

## Verification
The delicate overlap is a run ending in the same cycle that the next run is requested. The bench raises `start` in the very cycle `done` is high and expects the new run to be accepted. The second run must finish after the full NSV·(NATT+1) edges with the correct class, and the first result must already have been reported. A second overlap is a write or a `start` arriving mid-run. The bench presents both partway through a run and then judges only at the ports: the run's latency is unchanged, no extra `done` appears, and a following run shows the stored test vector untouched.

// File: rtl/lns_svm_pkg.sv
package lns_svm_pkg;

    localparam int LOG_W  = 10;
    localparam int FRAC_W = 4;
    localparam int LIN_P  = 12;
    localparam int WORD_W = LOG_W + 2;

    localparam int LG_MAX = (2 ** (LOG_W - 1)) - 1;
    localparam int LG_MIN = -(2 ** (LOG_W - 1));

    typedef struct packed {
        logic                    zero;
        logic                    neg;
        logic signed [LOG_W-1:0] lg;
    } lns_t;

    localparam lns_t LNS_ZERO = '{zero: 1'b1, neg: 1'b0, lg: '0};

    typedef enum logic [1:0] {
        SEL_TEST = 2'd0,
        SEL_SV   = 2'd1,
        SEL_COEF = 2'd2,
        SEL_BIAS = 2'd3
    } ld_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DOT  = 2'd1,
        ST_ACC  = 2'd2
    } st_e;

    function automatic logic signed [LOG_W-1:0] lg_sat(input int x);
        int c;
        c = x;
        if (c > LG_MAX) c = LG_MAX;
        if (c < LG_MIN) c = LG_MIN;
        return LOG_W'(c);
    endfunction

endpackage

// File: rtl/lns_mul.sv
module lns_mul
    import lns_svm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  lns_t a,
    input  lns_t b,
    output lns_t p
);

    always_comb begin
        if (a.zero || b.zero) begin
            p = LNS_ZERO;
        end else begin
            p.zero = 1'b0;
            p.neg  = a.neg ^ b.neg;
            p.lg   = lg_sat(int'(a.lg) + int'(b.lg));
        end
    end

    AST_MUL_ZERO: assert property (@(posedge clk) disable iff (rst) (a.zero || b.zero) |-> p.zero); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (!a.zero && !b.zero && a.lg > 0 && b.lg > 0) |-> (p.lg >= a.lg && p.lg >= b.lg)); // R12

endmodule

// File: rtl/lns_add.sv
module lns_add
    import lns_svm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  lns_t a,
    input  lns_t b,
    output lns_t s
);

    localparam logic [LIN_P:0] LIN_ONE = (LIN_P + 1)'(1) << LIN_P;
    localparam int             K_W     = LOG_W + 1 - FRAC_W;

    lns_t            big, sml;
    logic [LOG_W:0]  diff;
    logic [K_W-1:0]  k;
    logic [FRAC_W-1:0] f;
    logic [LIN_P:0]  mant, u, v;
    logic [FRAC_W-1:0] vfrac;
    int              p;
    int              res;

    // order operands by log magnitude
    always_comb begin
        if (a.lg >= b.lg) begin
            big = a;
            sml = b;
        end else begin
            big = b;
            sml = a;
        end
        diff = (LOG_W + 1)'({big.lg[LOG_W-1], big.lg} - {sml.lg[LOG_W-1], sml.lg});
        k    = diff[LOG_W:FRAC_W];
        f    = diff[FRAC_W-1:0];
    end

    // u = 2^-diff, piecewise-linear antilog in LIN_P fraction bits
    always_comb begin
        mant = LIN_ONE - ((LIN_P + 1)'(f) << (LIN_P - FRAC_W - 1));
        if (int'(k) > LIN_P) u = '0;
        else                 u = mant >> k;
        v = LIN_ONE - u;
    end

    // log2(v) by leading-one position and linear mantissa
    always_comb begin
        p = 0;
        for (int i = 0; i <= LIN_P; i++) begin
            if (v[i]) p = i;
        end
        vfrac = FRAC_W'(((int'(v) - (1 << p)) << (LIN_P - p)) >> (LIN_P - FRAC_W));
    end

    always_comb begin
        res = 0;
        s   = LNS_ZERO;
        if (a.zero) begin
            s = b;
        end else if (b.zero) begin
            s = a;
        end else if (a.neg == b.neg) begin
            res    = int'(big.lg) + int'(u[LIN_P:LIN_P-FRAC_W]);
            s.zero = 1'b0;
            s.neg  = big.neg;
            s.lg   = lg_sat(res);
        end else if (v == '0) begin
            s = LNS_ZERO;
        end else begin
            res    = int'(big.lg) + (p - LIN_P) * (2 ** FRAC_W) + int'(vfrac);
            s.zero = 1'b0;
            s.neg  = big.neg;
            s.lg   = lg_sat(res);
        end
    end

    AST_SAME_SIGN_GROWS: assert property (@(posedge clk) disable iff (rst) (!a.zero && !b.zero && a.neg == b.neg) |-> (!s.zero && s.neg == a.neg && s.lg >= a.lg && s.lg >= b.lg)); // R5
    AST_CANCEL_ZERO: assert property (@(posedge clk) disable iff (rst) (!a.zero && !b.zero && a.neg != b.neg && a.lg == b.lg) |-> s.zero); // R5
    AST_DIFF_SHRINKS: assert property (@(posedge clk) disable iff (rst) (!a.zero && !b.zero && a.neg != b.neg && !s.zero) |-> (s.lg <= a.lg || s.lg <= b.lg)); // R5

endmodule

// File: rtl/lns_svm_store.sv
module lns_svm_store
    import lns_svm_pkg::*;
#(
    parameter int NSV  = 8,
    parameter int NATT = 16,
    parameter int SV_IW = (NSV > 1) ? $clog2(NSV) : 1,
    parameter int AT_IW = (NATT > 1) ? $clog2(NATT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             busy,
    input  logic [1:0]       wr_sel,
    input  logic [SV_IW-1:0] wr_sv,
    input  logic [AT_IW-1:0] wr_att,
    input  lns_t             wr_word,
    input  logic [SV_IW-1:0] rd_sv,
    input  logic [AT_IW-1:0] rd_att,
    output lns_t             sv_o,
    output lns_t             test_o,
    output lns_t             coef_o,
    output lns_t             bias_o
);

    lns_t [NATT-1:0]           test_q;
    lns_t [NSV-1:0][NATT-1:0]  sv_q;
    lns_t [NSV-1:0]            coef_q;
    lns_t                      bias_q;

    logic sv_ok, att_ok;
    assign sv_ok  = int'(wr_sv)  < NSV;
    assign att_ok = int'(wr_att) < NATT;

    always_ff @(posedge clk) begin
        if (rst) begin
            test_q <= {NATT{LNS_ZERO}};
            sv_q   <= {(NSV * NATT){LNS_ZERO}};
            coef_q <= {NSV{LNS_ZERO}};
            bias_q <= LNS_ZERO;
        end else if (wr_en && !busy) begin
            case (ld_sel_e'(wr_sel))
                SEL_TEST: if (att_ok)          test_q[wr_att]       <= wr_word;
                SEL_SV:   if (att_ok && sv_ok) sv_q[wr_sv][wr_att]  <= wr_word;
                SEL_COEF: if (sv_ok)           coef_q[wr_sv]        <= wr_word;
                default:                       bias_q               <= wr_word;
            endcase
        end
    end

    assign sv_o   = sv_q[rd_sv][rd_att];
    assign test_o = test_q[rd_att];
    assign coef_o = coef_q[rd_sv];
    assign bias_o = bias_q;

    AST_LOAD_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst) busy |=> ($stable(test_q) && $stable(sv_q) && $stable(coef_q) && $stable(bias_q))); // R9

endmodule

// File: rtl/lns_svm_classifier.sv
module lns_svm_classifier
    import lns_svm_pkg::*;
#(
    parameter int NSV  = 8,
    parameter int NATT = 16,
    parameter int SV_IW = (NSV > 1) ? $clog2(NSV) : 1,
    parameter int AT_IW = (NATT > 1) ? $clog2(NATT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [1:0]        ld_sel,
    input  logic [SV_IW-1:0]  ld_sv,
    input  logic [AT_IW-1:0]  ld_att,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              start,
    output logic              done,
    output logic              cls_pos
);

    localparam int RUN_CYC = NSV * (NATT + 1);
    localparam int CNT_W   = $clog2(RUN_CYC + 2);

    st_e              st_q;
    logic [SV_IW-1:0] sv_idx_q;
    logic [AT_IW-1:0] att_idx_q;
    lns_t             dot_q, tot_q;
    logic             done_q, cls_q;
    logic             busy;

    lns_t sv_w, t_w, coef_w, bias_w;
    lns_t p_dot, p_acc, dot_n, tot_n;

    assign busy = (st_q != ST_IDLE);

    lns_svm_store #(.NSV(NSV), .NATT(NATT), .SV_IW(SV_IW), .AT_IW(AT_IW)) i_store (
        .clk(clk), .rst(rst), .wr_en(ld_en), .busy(busy), .wr_sel(ld_sel),
        .wr_sv(ld_sv), .wr_att(ld_att), .wr_word(lns_t'(ld_word)),
        .rd_sv(sv_idx_q), .rd_att(att_idx_q),
        .sv_o(sv_w), .test_o(t_w), .coef_o(coef_w), .bias_o(bias_w)
    );

    // kernel path: attribute product into the dot product
    lns_mul i_mul_dot (.clk(clk), .rst(rst), .a(sv_w),   .b(t_w),   .p(p_dot));
    lns_add i_add_dot (.clk(clk), .rst(rst), .a(dot_q),  .b(p_dot), .s(dot_n));
    // weighting path: weighted kernel into the running total
    lns_mul i_mul_acc (.clk(clk), .rst(rst), .a(coef_w), .b(dot_q), .p(p_acc));
    lns_add i_add_acc (.clk(clk), .rst(rst), .a(tot_q),  .b(p_acc), .s(tot_n));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            sv_idx_q  <= '0;
            att_idx_q <= '0;
            dot_q     <= LNS_ZERO;
            tot_q     <= LNS_ZERO;
            done_q    <= 1'b0;
            cls_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q      <= ST_DOT;
                        sv_idx_q  <= '0;
                        att_idx_q <= '0;
                        dot_q     <= LNS_ZERO;
                        tot_q     <= bias_w;
                    end
                end
                ST_DOT: begin
                    dot_q <= dot_n;
                    if (att_idx_q == AT_IW'(NATT - 1)) st_q <= ST_ACC;
                    else                               att_idx_q <= att_idx_q + 1'b1;
                end
                default: begin
                    tot_q <= tot_n;
                    if (sv_idx_q == SV_IW'(NSV - 1)) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                        cls_q  <= tot_n.zero | ~tot_n.neg;
                    end else begin
                        st_q      <= ST_DOT;
                        sv_idx_q  <= sv_idx_q + 1'b1;
                        att_idx_q <= '0;
                        dot_q     <= LNS_ZERO;
                    end
                end
            endcase
        end
    end

    assign done    = done_q;
    assign cls_pos = cls_q;

    // run-length checker
    logic [CNT_W-1:0] chk_cnt;
    always_ff @(posedge clk) begin
        if (rst)                      chk_cnt <= '0;
        else if (!busy && start)      chk_cnt <= '0;
        else if (busy)                chk_cnt <= chk_cnt + 1'b1;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R7
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst) done |-> (chk_cnt == CNT_W'(RUN_CYC))); // R7
    AST_CLASS_HOLD: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(cls_pos)); // R7
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst) busy |=> (sv_idx_q >= $past(sv_idx_q))); // R8

endmodule

// File: tb/test_lns_svm_classifier.sv
module test_lns_svm_classifier;

    localparam int CLK_PERIOD = 10;
    localparam int NSV  = 3;
    localparam int NATT = 4;
    localparam int RUN_CYC = NSV * (NATT + 1);
    localparam int NROW = 7;

    // test attributes in quarter units, last column = expected cls_pos
    localparam int TV [NROW][5] = '{
        '{ 8,  8,  0,  0, 1},
        '{ 0,  0,  8,  8, 0},
        '{-4, -4,  2,  2, 0},
        '{ 4, -4,  4, -4, 1},
        '{-4,  4, -4,  4, 0},
        '{ 0,  0,  0,  0, 1},
        '{ 2,  0,  0,  8, 0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_sel = '0;
    logic [1:0]  ld_sv = '0;
    logic [1:0]  ld_att = '0;
    logic [11:0] ld_word = '0;
    logic        start = 1'b0;
    logic        done;
    logic        cls_pos;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lns_svm_classifier #(.NSV(NSV), .NATT(NATT)) i_lns_svm_classifier (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_sv(ld_sv),
        .ld_att(ld_att), .ld_word(ld_word), .start(start),
        .done(done), .cls_pos(cls_pos)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // quarter-unit integer to log word (R1 layout)
    function automatic logic [11:0] enc(input int q);
        real m;
        int  l;
        if (q == 0) return 12'h800;
        m = (q < 0) ? -q / 4.0 : q / 4.0;
        l = int'($ln(m) / $ln(2.0) * 16.0);
        return {1'b0, (q < 0), 10'(l)};
    endfunction

    task automatic wr(input int sel, input int sv, input int att, input logic [11:0] w);
        ld_en = 1'b1; ld_sel = 2'(sel); ld_sv = 2'(sv); ld_att = 2'(att); ld_word = w;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // called at a negedge; returns at the negedge where done is seen
    task automatic run(input bit poke_st, input bit poke_ld, output int lat, output int c);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (1) begin
            if (lat == 4 && poke_st) start = 1'b1;
            if (lat == 4 && poke_ld) begin
                ld_en = 1'b1; ld_sel = 2'd0; ld_att = 2'd0; ld_word = enc(-32);
            end
            @(negedge clk);
            lat++;
            start = 1'b0;
            ld_en = 1'b0;
            if (done || lat > 100) break;
        end
        c = int'(cls_pos);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lat, c, c0, extra;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R11 done after reset", int'(done), 0);
        chk("R11 cls_pos after reset", int'(cls_pos), 0);

        // empty store after reset: total is exact zero
        run(0, 0, lat, c);
        chk("R11 R6 cleared store gives positive class", c, 1);
        chk("R7 latency", lat, RUN_CYC);

        // model: SV0=[1,1,0,0] w=+1, SV1=[0,0,1,1] w=-1, SV2=[1,-1,1,-1] w=+0.5, bias=+0.5
        for (int a = 0; a < NATT; a++) begin
            wr(1, 0, a, enc((a < 2) ? 4 : 0));
            wr(1, 1, a, enc((a < 2) ? 0 : 4));
            wr(1, 2, a, enc((a % 2 == 0) ? 4 : -4));
        end
        wr(2, 0, 0, enc(4));
        wr(2, 1, 0, enc(-4));
        wr(2, 2, 0, enc(2));
        wr(3, 0, 0, enc(2));

        for (int r = 0; r < NROW; r++) begin
            for (int a = 0; a < NATT; a++) wr(0, 0, a, enc(TV[r][a]));
            run(0, 0, lat, c);
            chk($sformatf("R2 R3 R4 R1 row %0d class", r), c, TV[r][4]);
            chk($sformatf("R7 row %0d latency", r), lat, RUN_CYC);
        end

        c0 = int'(cls_pos);
        repeat (5) @(negedge clk);
        chk("R7 class holds between runs", int'(cls_pos), c0);
        chk("R7 done is a single pulse", int'(done), 0);

        // start ignored while busy
        for (int a = 0; a < NATT; a++) wr(0, 0, a, enc(TV[0][a]));
        run(1, 0, lat, c);
        chk("R8 class with mid-run start", c, 1);
        chk("R8 latency with mid-run start", lat, RUN_CYC);
        extra = 0;
        for (int i = 0; i < RUN_CYC + 5; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R8 no second done", extra, 0);

        // write ignored while busy
        run(0, 1, lat, c);
        chk("R9 class with mid-run write", c, 1);
        @(negedge clk);
        run(0, 0, lat, c);
        chk("R9 stored test vector unchanged", c, 1);

        // start in the done cycle
        run(0, 0, lat, c);
        run(0, 0, lat, c);
        chk("R10 back-to-back latency", lat, RUN_CYC);
        chk("R10 back-to-back class", c, 1);

        // exact cancellation to zero: SV0 gives +2, SV1 gives -2
        wr(2, 2, 0, 12'h800);
        wr(3, 0, 0, 12'h800);
        for (int a = 0; a < NATT; a++) wr(0, 0, a, enc(4));
        run(0, 0, lat, c);
        chk("R6 R5 exact zero total is positive", c, 1);
        wr(3, 0, 0, enc(-2));
        run(0, 0, lat, c);
        chk("R2 R5 zero plus negative bias", c, 0);

        // saturation: 500 + 500 exceeds the log range
        wr(2, 1, 0, 12'h800);
        wr(1, 0, 0, {2'b00, 10'sd500});
        wr(0, 0, 0, {2'b00, 10'sd500});
        for (int a = 1; a < NATT; a++) wr(0, 0, a, 12'h800);
        wr(3, 0, 0, enc(-4));
        run(0, 0, lat, c);
        chk("R12 R1 saturated product dominates bias", c, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule